// File: doc/BRIEF.md
# Periodic Interrupt and Timing Pulse Generator

This block turns carry pulses from a calendar clock into a periodic event on an active-low, open-drain output, together with a readable interrupt flag. A two-bit period field picks the source: the 1/64-second carry, the seconds carry, the minutes carry or the hours carry. The event happens on the carry itself, so the block has no period counter of its own. Minute and hour carries reach it the same way whatever their cause, including a 30-second adjustment. Writes to the time digits never create a carry and so never reach this block.

A mode bit picks how the event is presented. In latched interrupt mode the output pulls low and stays low until software clears the flag. Carries that arrive while the flag is set are ignored. In waveform mode the output pulls low for a fixed 1/128 second, measured as 64 enables at the 8.192 kHz rate, and then releases by itself. A software clear ends the pulse early. A mask bit releases the output and blocks new events. The flag always shows whether the pin is being driven low.

The control is a three-state machine. `ST_IDLE` means released. `ST_HELD` means low until cleared. `ST_PULSE` means low while the width timer runs. The transitions are:
- `ST_IDLE` to `ST_HELD` on an event in latched mode (`EV_LATCH`), or to `ST_PULSE` on an event in waveform mode (`EV_PULSE`).
- `ST_PULSE` to `ST_IDLE` when the timer expires (`T_EXPIRE`).
- `ST_PULSE` to `ST_HELD` when the period or mode bits change (`CFG_FREEZE`).
- `ST_HELD` or `ST_PULSE` to `ST_IDLE` on a flag clear (`SW_CLEAR`) or on mask (`MASKED`). Mask has the highest priority, then clear, then the config change, then expiry.

Top module: `periodic_irq_gen`

## Requirements
- R1: After reset the drive output `pin_low_en` and `irq_flag` are both 0.
- R2: `period_sel` picks the event source: 00 the 1/64 s carry `carry_sub`, 01 `carry_sec`, 10 `carry_min`, 11 `carry_hour`. A carry that is not selected has no effect.
- R3: `irq_flag` equals `pin_low_en` in every cycle. Both become 1 on the clock edge after the one at which a selected carry is sampled with `mask` = 0 and the output released.
- R4: With `irq_mode` = 1 (latched) the output stays low until `flag_clr` is sampled. Selected carries that arrive while it is low change nothing.
- R5: With `irq_mode` = 0 (waveform) the output releases on the edge that samples the 64th `tick_8k` enable counted after the entry edge. This holds for every `period_sel` value.
- R6: `flag_clr` releases a low output on the next edge, in either mode. `flag_clr` has no effect when the output is already released.
- R7: While `mask` = 1 the output is released on the next edge and carries cause no event.
- R8: A change of `period_sel` or `irq_mode` from its value in the previous cycle, while a waveform pulse runs, stops the width timer. The output then stays low until `flag_clr`.
- R9: In waveform mode with `period_sel` = 00, 1/64 s carries every 128 enables and an enable in every cycle, the output is low for exactly half of the cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| carry_sub | input | 1 | 1/64-second carry pulse |
| carry_sec | input | 1 | Seconds carry pulse |
| carry_min | input | 1 | Minutes carry pulse |
| carry_hour | input | 1 | Hours carry pulse |
| tick_8k | input | 1 | 8.192 kHz-rate enable for the pulse width timer |
| period_sel | input | 2 | Event source select |
| irq_mode | input | 1 | 1 = latched interrupt, 0 = fixed-width waveform |
| mask | input | 1 | 1 = output released, events blocked |
| flag_clr | input | 1 | Strobe from software writing 0 to the flag |
| pin_low_en | output | 1 | Open-drain pull-down enable (1 = pin low) |
| irq_flag | output | 1 | Readable flag value |

## Verification
The assertions check on every cycle the relations between the ports: the flag matches the pin, a selected carry sets the output and an unselected one does not, a held interrupt survives until cleared, and a clear or a mask releases the output. The exact 64-enable pulse width, the timer freeze after a config change and the half duty at the fastest period depend on counts over long windows, so only the bench scenarios show them. A random phase compares the outputs against a bench model in every cycle.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int N_SRC       = 4;
    localparam int SEL_W       = $clog2(N_SRC);
    localparam int PULSE_TICKS = 64;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HELD  = 2'd1,
        ST_PULSE = 2'd2
    } pirq_state_e;
endpackage

// File: rtl/pirq_src_sel.sv
module pirq_src_sel #(
    parameter int N_SRC = 4,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] carries,
    input  logic [SEL_W-1:0] sel,
    output logic             event_hit
);
    logic [N_SRC-1:0] hit_vec;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign hit_vec[g] = carries[g] && (sel == SEL_W'(g));
    end

    assign event_hit = |hit_vec;
endmodule

// File: rtl/pirq_low_timer.sv
module pirq_low_timer #(
    parameter int TICKS = 64,
    localparam int CNT_W = $clog2(TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && tick && (cnt_q == LAST);
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
    import pirq_pkg::*;
#(
    parameter int PULSE_WIDTH = PULSE_TICKS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       carry_sub,
    input  logic       carry_sec,
    input  logic       carry_min,
    input  logic       carry_hour,
    input  logic       tick_8k,
    input  logic [1:0] period_sel,
    input  logic       irq_mode,
    input  logic       mask,
    input  logic       flag_clr,
    output logic       pin_low_en,
    output logic       irq_flag
);
    localparam int CFG_W = SEL_W + 1;

    pirq_state_e      state_q, state_d;
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_change;
    logic             sel_event;
    logic             pulse_done;
    logic             pulse_run;

    pirq_src_sel #(.N_SRC(N_SRC)) u_sel (
        .carries  ({carry_hour, carry_min, carry_sec, carry_sub}),
        .sel      (period_sel),
        .event_hit(sel_event)
    );

    assign pulse_run = (state_q == ST_PULSE);

    pirq_low_timer #(.TICKS(PULSE_WIDTH)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (pulse_run),
        .tick (tick_8k),
        .done (pulse_done)
    );

    // previous-cycle copy of the period and mode bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= {period_sel, irq_mode};
        end
    end

    assign cfg_change = (cfg_q != {period_sel, irq_mode});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: mask > clear > config freeze > expiry
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!mask && sel_event) begin
                    state_d = irq_mode ? ST_HELD : ST_PULSE;   // EV_LATCH / EV_PULSE
                end
            end
            ST_HELD: begin
                if (mask || flag_clr) begin
                    state_d = ST_IDLE;                         // MASKED / SW_CLEAR
                end
            end
            ST_PULSE: begin
                if (mask || flag_clr) begin
                    state_d = ST_IDLE;                         // MASKED / SW_CLEAR
                end else if (cfg_change) begin
                    state_d = ST_HELD;                         // CFG_FREEZE
                end else if (pulse_done) begin
                    state_d = ST_IDLE;                         // T_EXPIRE
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pin_low_en = 1'b0;
        unique case (state_q)
            ST_IDLE:  pin_low_en = 1'b0;
            ST_HELD:  pin_low_en = 1'b1;
            ST_PULSE: pin_low_en = 1'b1;
            default:  pin_low_en = 1'b0;
        endcase
        irq_flag = pin_low_en;
    end
endmodule

// File: rtl/pirq_chk.sv
module pirq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       carry_sub,
    input logic       carry_sec,
    input logic       carry_min,
    input logic       carry_hour,
    input logic       tick_8k,
    input logic [1:0] period_sel,
    input logic       irq_mode,
    input logic       mask,
    input logic       flag_clr,
    input logic       pin_low_en,
    input logic       irq_flag
);
    logic picked;
    always_comb begin
        case (period_sel)
            2'b00:   picked = carry_sub;
            2'b01:   picked = carry_sec;
            2'b10:   picked = carry_min;
            default: picked = carry_hour;
        endcase
    end

    logic unused_tick;
    assign unused_tick = tick_8k;

    assert_flag_matches_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag == pin_low_en);

    assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_low_en && !mask && picked |=> pin_low_en);

    assert_unselected_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_low_en && !picked |=> !pin_low_en);

    assert_latched_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pin_low_en && irq_mode && $stable(irq_mode) && !mask && !flag_clr |=> pin_low_en);

    assert_clear_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pin_low_en && flag_clr |=> !pin_low_en);

    assert_mask_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mask |=> !pin_low_en);
endmodule

bind periodic_irq_gen pirq_chk u_chk (.*);

// File: tb/periodic_irq_gen_tb.sv
module periodic_irq_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       carry_sub = 0, carry_sec = 0, carry_min = 0, carry_hour = 0;
    logic       tick_8k = 0;
    logic [1:0] period_sel = 2'b00;
    logic       irq_mode = 0, mask = 0, flag_clr = 0;
    logic       pin_low_en, irq_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    int cyc      = 0;

    // bench reference model
    bit       m_low, m_pulse;
    int       m_cnt;
    bit [2:0] m_prev;

    always #4 clk = ~clk;

    periodic_irq_gen u_dut (
        .clk(clk), .rst_n(rst_n),
        .carry_sub(carry_sub), .carry_sec(carry_sec),
        .carry_min(carry_min), .carry_hour(carry_hour),
        .tick_8k(tick_8k), .period_sel(period_sel), .irq_mode(irq_mode),
        .mask(mask), .flag_clr(flag_clr),
        .pin_low_en(pin_low_en), .irq_flag(irq_flag)
    );

    function automatic bit sel_carry(input bit [1:0] s, input bit a, input bit b,
                                     input bit c, input bit d);
        case (s)
            2'b00:   return a;
            2'b01:   return b;
            2'b10:   return c;
            default: return d;
        endcase
    endfunction

    task automatic model_step();
        bit chg, ev;
        chg = (m_prev != {period_sel, irq_mode});
        m_prev = {period_sel, irq_mode};
        ev = sel_carry(period_sel, carry_sub, carry_sec, carry_min, carry_hour);
        if (mask) m_low = 0;
        else if (!m_low) begin
            if (ev) begin m_low = 1; m_pulse = !irq_mode; m_cnt = 0; end
        end else if (flag_clr) m_low = 0;
        else if (m_pulse && chg) m_pulse = 0;
        else if (m_pulse && tick_8k) begin
            if (m_cnt == 63) m_low = 0; else m_cnt++;
        end
    endtask

    task automatic check(input string req, input bit exp_v);
        n_checks++;
        if (pin_low_en !== exp_v || irq_flag !== exp_v) begin
            n_fail++;
            $display("FAIL %s: pin_low_en=%b irq_flag=%b expected %b at cycle %0d",
                     req, pin_low_en, irq_flag, exp_v, cyc);
        end
    endtask

    // one clock: inputs already set, advance to next negedge, clear strobes
    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        carry_sub = 0; carry_sec = 0; carry_min = 0; carry_hour = 0;
        tick_8k = 0; flag_clr = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin tick_8k = 1; step(); end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int lows;
        void'($urandom(32'h5eed_1234));
        m_low = 0; m_pulse = 0; m_cnt = 0; m_prev = 0;
        repeat (3) @(negedge clk);
        check("R1 reset", 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", 0);

        // R2 / R3: seconds selected, latched
        period_sel = 2'b01; irq_mode = 1; step();
        carry_sub = 1; carry_min = 1; carry_hour = 1; step();
        check("R2 unselected carries", 0);
        carry_sec = 1; step();
        check("R3 event sets flag", 1);

        // R4: retriggers ignored, holds until clear
        for (int i = 0; i < 150; i++) begin carry_sec = 1; tick_8k = 1; step(); end
        check("R4 latched hold", 1);
        flag_clr = 1; step();
        check("R4 cleared", 0);
        flag_clr = 1; step();
        check("R6 clear while released", 0);

        // R5: waveform width, hour source
        period_sel = 2'b11; irq_mode = 0; step();
        carry_hour = 1; step();
        check("R5 pulse start", 1);
        ticks(63);
        check("R5 low after 63 enables", 1);
        repeat (5) step();
        check("R5 no enables, still low", 1);
        ticks(1);
        check("R5 released after 64 enables", 0);

        // R6: early clear in waveform mode
        period_sel = 2'b10; step();
        carry_min = 1; step();
        ticks(10);
        flag_clr = 1; step();
        check("R6 early clear", 0);

        // R7: mask
        mask = 1; carry_min = 1; step();
        check("R7 masked event", 0);
        mask = 0; irq_mode = 1; step();
        carry_min = 1; step();
        check("R7 setup latched", 1);
        mask = 1; step();
        check("R7 mask releases", 0);
        mask = 0; step();
        check("R7 stays released", 0);

        // R8: config change freezes pulse
        irq_mode = 0; step();
        carry_min = 1; step();
        ticks(5);
        period_sel = 2'b01; step();
        ticks(100);
        check("R8 frozen low", 1);
        flag_clr = 1; step();
        check("R8 cleared", 0);

        // R9: half duty at 1/64 s
        period_sel = 2'b00; irq_mode = 0; step(); step();
        lows = 0;
        for (int i = 0; i < 1280; i++) begin
            tick_8k = 1;
            carry_sub = (i % 128 == 0);
            step();
            if (pin_low_en) lows++;
        end
        n_checks++;
        if (lows != 640) begin
            n_fail++;
            $display("FAIL R9 duty: low cycles=%0d expected 640", lows);
        end
        for (int i = 0; i < 70; i++) begin tick_8k = 1; step(); end

        // random phase against model
        for (int i = 0; i < 6000; i++) begin
            carry_sub  = ($urandom % 200) == 0;
            carry_sec  = ($urandom % 150) == 0;
            carry_min  = ($urandom % 150) == 0;
            carry_hour = ($urandom % 150) == 0;
            tick_8k    = $urandom % 2;
            flag_clr   = ($urandom % 300) == 0;
            if (($urandom % 400) == 0) period_sel = 2'($urandom);
            if (($urandom % 500) == 0) irq_mode = ~irq_mode;
            if (($urandom % 100) == 0) mask = ~mask;
            else if (mask && ($urandom % 4) == 0) mask = 0;
            step();
            check("R2/R4/R5/R6/R7/R8 model compare", m_low);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule